// File: doc/BRIEF.md
# Rank-Sequential Refresh Manager

This block produces refresh work for one memory channel that carries several ranks. A programmable interval timer fires at a fixed period. Each firing is charged to one rank, taken in turn, and adds one postponed refresh to that rank's ledger. One refresh to a rank covers every bank and every row group belonging to the current slot of the retention window. A slot-validity mask marks which slots hold live data. A firing that lands on an empty slot adds nothing, so rows without valid data are never refreshed.

The command scheduler sees one request line, a rank number and an urgency flag. It grants the request when it can. Only one rank is refreshed at a time: after a grant the chosen rank is busy for a programmable number of cycles, and no further request is raised until that window closes. Pending ranks are served in round-robin order.

When traffic stops, the block can hand the channel to device self-refresh through a request/acknowledge handshake. On return it queues exactly one refresh for every rank before normal operation resumes.

The controller is a five-state machine:
- ST_RUN: normal operation. It moves to ST_SR_ENTRY after a qualified idle period.
- ST_SR_ENTRY: the self-refresh request is raised. It moves to ST_SR_HOLD on acknowledge, or to ST_SR_EXIT if the idle input drops first.
- ST_SR_HOLD: the devices refresh themselves. It moves to ST_SR_EXIT when the idle input drops.
- ST_SR_EXIT: the request is withdrawn. It moves to ST_FLUSH when the acknowledge falls, and that transition queues one refresh for every rank.
- ST_FLUSH: the queued refreshes are served. It returns to ST_RUN once nothing is pending and no rank is busy.

Top module: `rank_refresh_mgr`

## Requirements
- R1: In ST_RUN or ST_FLUSH, the interval timer fires once every `cfg_trefi` cycles, the first firing `cfg_trefi` cycles after reset release. Each firing is charged to the rank named by a tick pointer, which steps 0,1,…,NUM_RANKS-1 and wraps. The slot index steps by one, wrapping after NUM_SLOTS, each time the tick pointer wraps.
- R2: A firing while the slot index is s adds a pending refresh only when `slot_valid[s]` is 1. Otherwise it adds nothing.
- R3: Each rank holds at most MAX_POSTPONE (default 8) pending refreshes, and further firings saturate. `ref_urgent` is 1 exactly when a request is raised for a rank holding MAX_POSTPONE.
- R4: Once raised, `ref_req` stays high and `ref_rank` stays unchanged until `ref_grant` is sampled high.
- R5: Requests go to pending ranks in round-robin order, starting at rank 0 after reset and otherwise at the rank after the last one granted. Each grant removes one pending refresh, and `ref_req` is low when nothing is pending.
- R6: After a grant, `rank_busy` is one-hot on the granted rank for exactly `cfg_trfc` cycles. No request is raised while any bit of `rank_busy` is set.
- R7: `sr_req` rises only after `idle_in` has been held for `cfg_idle` consecutive cycles in ST_RUN with nothing pending and no rank busy. It never rises while a refresh is pending.
- R8: While `sr_active` is high (ST_SR_HOLD, reached on `sr_ack`), `sr_req` stays high, no request is raised, and the interval timer does not advance.
- R9: When `idle_in` falls, `sr_req` falls. Once `sr_ack` falls, one refresh is queued for every rank, regardless of `slot_valid`.
- R10: During and right after reset, `ref_req`, `ref_urgent`, `rank_busy`, `sr_req` and `sr_active` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trefi | input | CW | Refresh interval in cycles |
| cfg_trfc | input | CW | Busy window per refresh in cycles |
| cfg_idle | input | CW | Idle cycles required before self-refresh entry |
| slot_valid | input | NUM_SLOTS | Bit s set: slot s holds valid data |
| idle_in | input | 1 | Low-traffic indication from the scheduler |
| ref_grant | input | 1 | Scheduler accepts the current refresh request |
| sr_ack | input | 1 | Devices have entered (high) or left (low) self-refresh |
| ref_req | output | 1 | Refresh request |
| ref_rank | output | RW | Rank targeted by the request |
| ref_urgent | output | 1 | Targeted rank has reached the postponement limit |
| rank_busy | output | NUM_RANKS | One-hot rank currently in its refresh window |
| sr_req | output | 1 | Request to place the devices in self-refresh |
| sr_active | output | 1 | Channel is in self-refresh |

## Verification
The checker watches, on every cycle, the properties that need no history beyond one edge. These are: a single busy rank and no request during a busy window; a request that holds with a stable rank until granted; urgency only alongside a request; silence while in self-refresh; and self-refresh entry only from a cycle with no pending or busy work. The bench's scenarios are needed for the counting behaviour that spans many intervals. Only they can show the charging of firings to ranks and slots, skipping of empty slots, saturation at eight, the round-robin order of grants, the exact idle threshold, the paused timer during self-refresh and the one-per-rank flush after exit.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_SR_ENTRY,
        ST_SR_HOLD,
        ST_SR_EXIT,
        ST_FLUSH
    } rr_state_e;
endpackage

// File: rtl/rr_interval_timer.sv
`timescale 1ns/1ps
module rr_interval_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] period,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = en && (cnt >= period - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rr_pending_ledger.sv
`timescale 1ns/1ps
module rr_pending_ledger #(
    parameter int NUM_RANKS    = 4,
    parameter int MAX_POSTPONE = 8,
    localparam int PW = $clog2(MAX_POSTPONE + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RANKS-1:0] inc_vec,
    input  logic [NUM_RANKS-1:0] dec_vec,
    output logic [NUM_RANKS-1:0] pend_nz,
    output logic [NUM_RANKS-1:0] pend_full
);
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic [PW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (inc_vec[r] && !dec_vec[r] && cnt != PW'(MAX_POSTPONE)) begin
                cnt <= cnt + PW'(1);
            end else if (dec_vec[r] && !inc_vec[r] && cnt != '0) begin
                cnt <= cnt - PW'(1);
            end
        end

        assign pend_nz[r]   = (cnt != '0);
        assign pend_full[r] = (cnt == PW'(MAX_POSTPONE));
    end
endmodule

// File: rtl/rr_rr_picker.sv
`timescale 1ns/1ps
module rr_rr_picker #(
    parameter int NUM_RANKS = 4,
    localparam int RW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic [NUM_RANKS-1:0] cand,
    input  logic [RW-1:0]        start,
    output logic                 found,
    output logic [RW-1:0]        sel
);
    always_comb begin
        found = 1'b0;
        sel   = start;
        for (int i = NUM_RANKS - 1; i >= 0; i--) begin
            int idx;
            idx = (int'(start) + i) % NUM_RANKS;
            if (cand[idx]) begin
                found = 1'b1;
                sel   = RW'(idx);
            end
        end
    end
endmodule

// File: rtl/rank_refresh_mgr.sv
`timescale 1ns/1ps
module rank_refresh_mgr
    import rr_pkg::*;
#(
    parameter int NUM_RANKS    = 4,
    parameter int NUM_SLOTS    = 4,
    parameter int MAX_POSTPONE = 8,
    parameter int CW           = 16,
    localparam int RW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        cfg_trefi,
    input  logic [CW-1:0]        cfg_trfc,
    input  logic [CW-1:0]        cfg_idle,
    input  logic [NUM_SLOTS-1:0] slot_valid,
    input  logic                 idle_in,
    input  logic                 ref_grant,
    input  logic                 sr_ack,
    output logic                 ref_req,
    output logic [RW-1:0]        ref_rank,
    output logic                 ref_urgent,
    output logic [NUM_RANKS-1:0] rank_busy,
    output logic                 sr_req,
    output logic                 sr_active
);
    rr_state_e state, nxt;

    logic [RW-1:0]        tick_ptr, svc_ptr, busy_rank, hold_rank, pick_sel;
    logic [SW-1:0]        slot_idx;
    logic [CW-1:0]        busy_cnt, idle_cnt;
    logic                 hold_vld, pick_found, tick, timer_en;
    logic                 busy, any_pend, tick_add, flush_evt, grant_ok;
    logic                 idle_qual, idle_done, serving;
    logic [NUM_RANKS-1:0] inc_vec, dec_vec, pend_nz, pend_full;

    assign serving   = (state == ST_RUN) || (state == ST_FLUSH);
    assign timer_en  = serving;
    assign busy      = (busy_cnt != '0);
    assign any_pend  = |pend_nz;
    assign tick_add  = tick && slot_valid[slot_idx];
    assign flush_evt = (state == ST_SR_EXIT) && !sr_ack;
    assign grant_ok  = ref_req && ref_grant;
    assign idle_qual = idle_in && !any_pend && !busy;
    assign idle_done = ({1'b0, idle_cnt} + (CW+1)'(1)) >= {1'b0, cfg_idle};

    rr_interval_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (timer_en),
        .period (cfg_trefi),
        .tick   (tick)
    );

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_vec
        assign inc_vec[r]   = flush_evt || (tick_add && tick_ptr == RW'(r));
        assign dec_vec[r]   = grant_ok && (ref_rank == RW'(r));
        assign rank_busy[r] = busy && (busy_rank == RW'(r));
    end

    rr_pending_ledger #(.NUM_RANKS(NUM_RANKS), .MAX_POSTPONE(MAX_POSTPONE)) u_ledger (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_vec   (inc_vec),
        .dec_vec   (dec_vec),
        .pend_nz   (pend_nz),
        .pend_full (pend_full)
    );

    rr_rr_picker #(.NUM_RANKS(NUM_RANKS)) u_picker (
        .cand  (pend_nz),
        .start (svc_ptr),
        .found (pick_found),
        .sel   (pick_sel)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:      if (idle_qual && !tick && idle_done) nxt = ST_SR_ENTRY;
            ST_SR_ENTRY: if (sr_ack) nxt = ST_SR_HOLD;
                         else if (!idle_in) nxt = ST_SR_EXIT;
            ST_SR_HOLD:  if (!idle_in) nxt = ST_SR_EXIT;
            ST_SR_EXIT:  if (!sr_ack) nxt = ST_FLUSH;
            ST_FLUSH:    if (!any_pend && !busy) nxt = ST_RUN;
            default:     nxt = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        ref_req    = serving && !busy && (hold_vld || pick_found);
        ref_rank   = hold_vld ? hold_rank : pick_sel;
        ref_urgent = ref_req && pend_full[ref_rank];
        sr_req     = (state == ST_SR_ENTRY) || (state == ST_SR_HOLD);
        sr_active  = (state == ST_SR_HOLD);
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_ptr  <= '0;
            slot_idx  <= '0;
            svc_ptr   <= '0;
            busy_cnt  <= '0;
            busy_rank <= '0;
            hold_vld  <= 1'b0;
            hold_rank <= '0;
            idle_cnt  <= '0;
        end else begin
            if (tick) begin
                if (tick_ptr == RW'(NUM_RANKS - 1)) begin
                    tick_ptr <= '0;
                    slot_idx <= (slot_idx == SW'(NUM_SLOTS - 1)) ? '0 : slot_idx + SW'(1);
                end else begin
                    tick_ptr <= tick_ptr + RW'(1);
                end
            end
            if (grant_ok) begin
                busy_cnt  <= cfg_trfc;
                busy_rank <= ref_rank;
                svc_ptr   <= (ref_rank == RW'(NUM_RANKS - 1)) ? '0 : ref_rank + RW'(1);
                hold_vld  <= 1'b0;
            end else begin
                if (busy) busy_cnt <= busy_cnt - CW'(1);
                if (ref_req) begin
                    hold_vld  <= 1'b1;
                    hold_rank <= ref_rank;
                end
            end
            if (state == ST_RUN && idle_qual) idle_cnt <= idle_cnt + CW'(1);
            else                              idle_cnt <= '0;
        end
    end
endmodule

// File: rtl/rr_refresh_checker.sv
`timescale 1ns/1ps
module rr_refresh_checker #(
    parameter int NUM_RANKS = 4,
    parameter int CW        = 16,
    localparam int RW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ref_req,
    input logic                 ref_grant,
    input logic [RW-1:0]        ref_rank,
    input logic                 ref_urgent,
    input logic [NUM_RANKS-1:0] rank_busy,
    input logic                 sr_req,
    input logic                 sr_active,
    input logic [CW-1:0]        cfg_trfc
);
    p_busy_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rank_busy));

    p_serial_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rank_busy != '0) |-> !ref_req);

    p_grant_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_grant && cfg_trfc != '0) |=> (rank_busy != '0));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_grant) |=> (ref_req && $stable(ref_rank)));

    p_urgent_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    p_sr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> (!ref_req && sr_req));

    p_sr_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_req) |-> ($past(!ref_req) && $past(rank_busy == '0)));
endmodule

bind rank_refresh_mgr rr_refresh_checker #(.NUM_RANKS(NUM_RANKS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_req    (ref_req),
    .ref_grant  (ref_grant),
    .ref_rank   (ref_rank),
    .ref_urgent (ref_urgent),
    .rank_busy  (rank_busy),
    .sr_req     (sr_req),
    .sr_active  (sr_active),
    .cfg_trfc   (cfg_trfc)
);

// File: tb/sim_rank_refresh_mgr.sv
`timescale 1ns/1ps
module sim_rank_refresh_mgr;
    localparam int N  = 4;
    localparam int S  = 4;
    localparam int MP = 8;
    localparam int CW = 16;
    localparam int TREFI = 400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_trefi = CW'(TREFI);
    logic [CW-1:0] cfg_trfc = CW'(2);
    logic [CW-1:0] cfg_idle = CW'(20);
    logic [S-1:0]  slot_valid = '1;
    logic          idle_in = 1'b0, ref_grant = 1'b0, sr_ack = 1'b0;
    logic          ref_req, ref_urgent, sr_req, sr_active;
    logic [1:0]    ref_rank;
    logic [N-1:0]  rank_busy;

    always #2.5 clk = ~clk;

    rank_refresh_mgr #(.NUM_RANKS(N), .NUM_SLOTS(S), .MAX_POSTPONE(MP), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_trefi(cfg_trefi), .cfg_trfc(cfg_trfc),
        .cfg_idle(cfg_idle), .slot_valid(slot_valid), .idle_in(idle_in),
        .ref_grant(ref_grant), .sr_ack(sr_ack), .ref_req(ref_req),
        .ref_rank(ref_rank), .ref_urgent(ref_urgent), .rank_busy(rank_busy),
        .sr_req(sr_req), .sr_active(sr_active)
    );

    int errs = 0, checks = 0;
    int g_rank[64], g_urg[64], g_n;
    int e_rank[64], e_urg[64], e_n;
    int busy_bad;

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [S-1:0] mask, input int trfc, input bit idl);
        @(negedge clk);
        rst_n = 1'b0; ref_grant = 1'b0; sr_ack = 1'b0;
        slot_valid = mask; cfg_trfc = CW'(trfc); idle_in = idl;
        repeat (3) @(negedge clk);
        chk_eq("R10 req in reset", int'(ref_req), 0);
        rst_n = 1'b1;
    endtask

    // expected grant sequence: k firings, slot mask, optional one-per-rank flush
    task automatic build_exp(input int k, input logic [S-1:0] mask, input bit flush);
        int cnt[N];
        int ptr;
        for (int r = 0; r < N; r++) cnt[r] = flush ? 1 : 0;
        for (int j = 0; j < k; j++) begin
            int r = j % N;
            int s = (j / N) % S;
            if (mask[s] && cnt[r] < MP) cnt[r]++;
        end
        e_n = 0; ptr = 0;
        for (int g = 0; g < 64; g++) begin
            int pick = -1;
            for (int i = N - 1; i >= 0; i--) if (cnt[(ptr + i) % N] > 0) pick = (ptr + i) % N;
            if (pick < 0) break;
            e_rank[e_n] = pick;
            e_urg[e_n]  = (cnt[pick] == MP) ? 1 : 0;
            cnt[pick]--;
            e_n++;
            ptr = (pick + 1) % N;
        end
    endtask

    task automatic drain(input int trfc);
        g_n = 0; busy_bad = 0;
        for (int it = 0; it < 64; it++) begin
            int w = 0;
            int b = 0;
            while (!ref_req && w < 12) begin @(negedge clk); w++; end
            if (!ref_req) break;
            g_rank[g_n] = int'(ref_rank);
            g_urg[g_n]  = int'(ref_urgent);
            if (g_n == 0) begin
                repeat (3) @(negedge clk);
                chk_eq("R4 request held", int'(ref_req), 1);
                chk_eq("R4 rank stable", int'(ref_rank), g_rank[0]);
            end
            ref_grant = 1'b1;
            @(negedge clk);
            ref_grant = 1'b0;
            while (rank_busy != '0 && b < 100) begin
                if (rank_busy != N'(1 << g_rank[g_n]) || ref_req) busy_bad++;
                b++;
                @(negedge clk);
            end
            if (b != trfc) busy_bad++;
            g_n++;
        end
        chk_eq("R6 busy window and serialization", busy_bad, 0);
    endtask

    task automatic compare(input string tag);
        int mo = 0, mu = 0;
        chk_eq({tag, " grant count"}, g_n, e_n);
        for (int i = 0; i < e_n && i < g_n; i++) begin
            if (g_rank[i] != e_rank[i]) mo++;
            if (g_urg[i] != e_urg[i]) mu++;
        end
        chk_eq({tag, " R5 round-robin order"}, mo, 0);
        chk_eq({tag, " R3 urgency"}, mu, 0);
    endtask

    task automatic run_ticks(input int k, input logic [S-1:0] mask, input int trfc, input string tag);
        do_reset(mask, trfc, 1'b0);
        repeat (k * TREFI + TREFI / 2) @(negedge clk);
        drain(trfc);
        build_exp(k, mask, 1'b0);
        compare(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int seen;
        // R10 reset state
        do_reset(4'b1111, 2, 1'b0);
        @(negedge clk);
        chk_eq("R10 ref_req", int'(ref_req), 0);
        chk_eq("R10 rank_busy", int'(rank_busy), 0);
        chk_eq("R10 sr_req", int'(sr_req), 0);
        chk_eq("R10 sr_active", int'(sr_active), 0);
        chk_eq("R10 ref_urgent", int'(ref_urgent), 0);

        // R1 first firing timing, then charging over ranks and slots
        do_reset(4'b1011, 2, 1'b0);
        repeat (TREFI - 1) @(negedge clk);
        chk_eq("R1 no request before interval", int'(ref_req), 0);
        @(negedge clk);
        chk_eq("R1 request at interval", int'(ref_req), 1);
        chk_eq("R1 first rank", int'(ref_rank), 0);
        repeat (5 * TREFI + TREFI / 2) @(negedge clk);
        drain(2);
        build_exp(6, 4'b1011, 1'b0);
        compare("R1");

        // R2 slot skipping, R6 longer busy window
        run_ticks(16, 4'b0101, 5, "R2 mixed mask");
        run_ticks(8, 4'b0000, 2, "R2 empty mask");

        // R3 saturation and urgency boundary
        run_ticks(40, 4'b1111, 2, "R3 saturated");
        run_ticks(28, 4'b1111, 3, "R3 below limit");

        // R7 pending work blocks entry
        do_reset(4'b1111, 2, 1'b0);
        repeat (TREFI) @(negedge clk);
        idle_in = 1'b1;
        repeat (100) @(negedge clk);
        chk_eq("R7 no entry while pending", int'(sr_req), 0);
        chk_eq("R7 request still raised", int'(ref_req), 1);
        ref_grant = 1'b1; @(negedge clk); ref_grant = 1'b0;
        seen = 0;
        for (int i = 0; i < 40 && !sr_req; i++) @(negedge clk);
        chk_eq("R7 entry after work drained", int'(sr_req), 1);

        // R7 exact threshold, R8 hold, R9 flush
        do_reset(4'b1111, 2, 1'b1);
        repeat (19) @(negedge clk);
        chk_eq("R7 before threshold", int'(sr_req), 0);
        @(negedge clk);
        chk_eq("R7 at threshold", int'(sr_req), 1);
        repeat (5) @(negedge clk);
        chk_eq("R7 request held without ack", int'(sr_req), 1);
        chk_eq("R8 inactive before ack", int'(sr_active), 0);
        sr_ack = 1'b1;
        @(negedge clk);
        chk_eq("R8 active after ack", int'(sr_active), 1);
        for (int i = 0; i < 8 * TREFI; i++) begin
            if (ref_req || !sr_req) seen++;
            @(negedge clk);
        end
        chk_eq("R8 quiet in self-refresh", seen, 0);
        idle_in = 1'b0;
        @(negedge clk);
        chk_eq("R9 sr_req drops", int'(sr_req), 0);
        chk_eq("R9 sr_active drops", int'(sr_active), 0);
        repeat (3) @(negedge clk);
        chk_eq("R9 no request before ack falls", int'(ref_req), 0);
        sr_ack = 1'b0;
        @(negedge clk);
        chk_eq("R9 flush request", int'(ref_req), 1);
        drain(2);
        build_exp(0, 4'b1111, 1'b1);
        compare("R8 R9 flush");

        // R9 flush ignores the mask
        do_reset(4'b0000, 2, 1'b1);
        repeat (25) @(negedge clk);
        sr_ack = 1'b1;
        repeat (50) @(negedge clk);
        idle_in = 1'b0;
        @(negedge clk);
        sr_ack = 1'b0;
        @(negedge clk);
        drain(2);
        build_exp(0, 4'b0000, 1'b1);
        compare("R9 empty-mask flush");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule